// File: doc/BRIEF.md
# Store Staging Queue with Read-Miss Priority

This block sits between a write-through cache and a slower memory. Every processor store is also handed to this queue as an address and data pair. The queue keeps the stores in arrival order and offers the oldest one to memory through a drain port. Memory takes an entry on any cycle in which it raises its ready input. If stores arrive faster than memory can accept them, the queue fills. It then lowers its push-ready output, and the processor side has to stall.

A read miss does not wait for the queue to empty. The requested address is compared, at block granularity, against every valid queued entry at the same time. If no entry falls in the same block, the read is granted at once and goes ahead of the queued stores. For that cycle the drain port is held off. If one or more entries match, draining continues in order. The grant comes in the first cycle in which no matching entry is left. Cache arrays and memory timing live outside the block.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty. `push_ready` is 1, while `drain_valid` and `rd_grant` are 0.
- R2: Entries leave through the drain port in the order they were accepted, each with its original address and data. An entry is accepted on a clock edge where `push_valid` and `push_ready` are both 1. It is removed on an edge where `drain_valid` and `drain_ready` are both 1.
- R3: While `drain_valid` is 1 and `drain_ready` is 0, with no grant in between, `drain_addr` and `drain_data` hold their values.
- R4: The queue holds DEPTH entries (default 4). When it is full, `push_ready` is 0 and any push offered is ignored. Draining afterwards yields exactly the DEPTH accepted entries.
- R5: An accepted push and a drain on the same edge leave the occupancy unchanged.
- R6: With a read request pending and no queued entry in the requested block, `rd_grant` is 1 in the same cycle and `drain_valid` is 0 while the grant is high.
- R7: Two addresses are in the same block when they are equal above the low OFF_W offset bits (default 2). A request that hits a queued block keeps `rd_grant` at 0 while draining continues, and the grant comes once the matching entry has left.
- R8: When several queued entries hit the requested block, the grant waits until the last of them has drained.
- R9: A read request to an empty queue is granted in the same cycle.
- R10: While the queue is non-empty and no grant is given, `drain_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Store offered by the processor side |
| push_addr | input | AW | Store address |
| push_data | input | DW | Store data |
| push_ready | output | 1 | Queue can accept a store |
| drain_valid | output | 1 | Oldest entry offered to memory |
| drain_addr | output | AW | Address of oldest entry |
| drain_data | output | DW | Data of oldest entry |
| drain_ready | input | 1 | Memory accepts the offered entry |
| rd_req | input | 1 | Read miss wants memory |
| rd_addr | input | AW | Read miss address |
| rd_grant | output | 1 | Read may proceed to memory this cycle |

## Verification
The grant and the drain hold-off are combinational, so they are due in the same cycle as the request. Every push or drain handshake changes the head and occupancy at the next edge, so its effect is due one cycle later. The bench drives inputs shortly after a rising edge and samples at the falling edge. The grant delays in R7 and R8 are checked one falling edge at a time: with two entries of which the second matches, the grant must come on the third sample, and with three entries it must come on the fourth. A scoreboard queue filled by the push task is compared against every drain handshake the monitor sees.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int WB_AW    = 16;
    localparam int WB_DW    = 16;
    localparam int WB_DEPTH = 4;
    localparam int WB_OFF_W = 2;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_DRAIN = 2'd1,
        ARB_READ  = 2'd2,
        ARB_WAIT  = 2'd3
    } arb_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    output logic             full,
    output logic             empty,
    output logic [AW-1:0]    ent_addr [DEPTH],
    output logic [DEPTH-1:0] ent_vld
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q[wp_q] <= wr_addr;
            data_q[wp_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            vld_q <= '0;
        end else begin
            if (rd_en) begin
                vld_q[rp_q] <= 1'b0;
                rp_q        <= ptr_inc(rp_q);
            end
            if (wr_en) begin
                vld_q[wp_q] <= 1'b1;
                wp_q        <= ptr_inc(wp_q);
            end
            cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign head_addr = addr_q[rp_q];
    assign head_data = data_q[rp_q];
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign ent_addr  = addr_q;
    assign ent_vld   = vld_q;
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int OFF_W = 2
) (
    input  logic [AW-1:0]    probe,
    input  logic [AW-1:0]    ent_addr [DEPTH],
    input  logic [DEPTH-1:0] ent_vld,
    output logic             hit
);
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = ent_vld[g] && (ent_addr[g][AW-1:OFF_W] == probe[AW-1:OFF_W]);
    end

    assign hit = |eq;
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic rd_req,
    input  logic hit,
    input  logic empty,
    output logic rd_grant,
    output logic drain_en
);
    arb_e dec;

    always_comb begin
        if (rd_req && !hit)       dec = ARB_READ;
        else if (empty)           dec = ARB_IDLE;
        else if (rd_req)          dec = ARB_WAIT;
        else                      dec = ARB_DRAIN;
    end

    assign rd_grant = (dec == ARB_READ);
    assign drain_en = (dec == ARB_DRAIN) || (dec == ARB_WAIT);
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH,
    parameter int AW    = WB_AW,
    parameter int DW    = WB_DW,
    parameter int OFF_W = WB_OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    output logic          drain_valid,
    output logic [AW-1:0] drain_addr,
    output logic [DW-1:0] drain_data,
    input  logic          drain_ready,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_grant
);
    logic             full, empty, hit, drain_en;
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [DEPTH-1:0] ent_vld;

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (push_valid && !full),
        .wr_addr   (push_addr),
        .wr_data   (push_data),
        .rd_en     (drain_en && drain_ready),
        .head_addr (drain_addr),
        .head_data (drain_data),
        .full      (full),
        .empty     (empty),
        .ent_addr  (ent_addr),
        .ent_vld   (ent_vld)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .OFF_W(OFF_W)) u_match (
        .probe    (rd_addr),
        .ent_addr (ent_addr),
        .ent_vld  (ent_vld),
        .hit      (hit)
    );

    wbuf_arb u_arb (
        .rd_req   (rd_req),
        .hit      (hit),
        .empty    (empty),
        .rd_grant (rd_grant),
        .drain_en (drain_en)
    );

    assign push_ready  = !full;
    assign drain_valid = drain_en;
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push_valid,
    input logic          push_ready,
    input logic          drain_valid,
    input logic [AW-1:0] drain_addr,
    input logic [DW-1:0] drain_data,
    input logic          drain_ready,
    input logic          rd_req,
    input logic          rd_grant
);
    logic [CW-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + CW'(push_valid && push_ready) - CW'(drain_valid && drain_ready);
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (push_ready && !drain_valid && !rd_grant)); // R1

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && !drain_ready && !rd_req) |=>
        (rd_grant || (drain_valid && $stable(drain_addr) && $stable(drain_data)))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push_ready == (occ != CW'(DEPTH))); // R4

    AST_GRANT_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> (rd_req && !drain_valid)); // R6

    AST_DRAIN_OFFERED: assert property (@(posedge clk) disable iff (rst)
        ((occ != '0) && !rd_grant) |-> drain_valid); // R10

    AST_NO_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !drain_valid); // R2
endmodule

bind wbuf_top wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_valid  (push_valid),
    .push_ready  (push_ready),
    .drain_valid (drain_valid),
    .drain_addr  (drain_addr),
    .drain_data  (drain_data),
    .drain_ready (drain_ready),
    .rd_req      (rd_req),
    .rd_grant    (rd_grant)
);

// File: tb/sim_wbuf_top.sv
module sim_wbuf_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [15:0] push_addr = '0;
    logic [15:0] push_data = '0;
    logic        push_ready;
    logic        drain_valid;
    logic [15:0] drain_addr;
    logic [15:0] drain_data;
    logic        drain_ready = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_grant;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    wbuf_top u0 (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
        .push_ready(push_ready),
        .drain_valid(drain_valid), .drain_addr(drain_addr), .drain_data(drain_data),
        .drain_ready(drain_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_grant(rd_grant)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Monitor: a drain handshake seen at the falling edge completes at the next rising edge.
    always @(negedge clk) begin
        if (!rst && drain_valid && drain_ready) begin
            if (exp_q.size() == 0) begin
                chk("R2 drain with nothing expected", {drain_addr, drain_data}, 32'hx);
            end else begin
                chk("R2 drain order", {drain_addr, drain_data}, exp_q.pop_front());
            end
        end
    end

    task automatic try_push(input logic [15:0] a, input logic [15:0] d, output bit acc);
        push_valid = 1'b1;
        push_addr  = a;
        push_data  = d;
        @(negedge clk);
        acc = push_ready;
        if (acc) exp_q.push_back({a, d});
        step();
        push_valid = 1'b0;
    endtask

    task automatic drain_all();
        drain_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!drain_valid) break;
        end
        step();
        drain_ready = 1'b0;
        chk("R2 scoreboard empty", exp_q.size(), 0);
    endtask

    initial begin
        bit acc;
        int cnt;
        logic [15:0] ha, hd;
        logic g [4];

        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 push_ready", push_ready, 1);
        chk("R1 drain_valid", drain_valid, 0);
        chk("R1 rd_grant", rd_grant, 0);

        // R2 / R3 / R10: order, hold while memory busy
        step();
        try_push(16'h1000, 16'hA001, acc);
        try_push(16'h1010, 16'hA002, acc);
        try_push(16'h1020, 16'hA003, acc);
        @(negedge clk);
        chk("R10 drain_valid when non-empty", drain_valid, 1);
        ha = drain_addr; hd = drain_data;
        repeat (3) @(negedge clk);
        chk("R3 head addr held", drain_addr, ha);
        chk("R3 head data held", drain_data, hd);
        chk("R2 head is oldest", {drain_addr, drain_data}, 32'h1000A001);
        step();
        drain_all();

        // R4: full queue ignores further pushes
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            try_push(16'h2000 + 16'(i * 16), 16'hB000 + 16'(i), acc);
            if (acc) cnt++;
        end
        chk("R4 accepted count", cnt, 4);
        @(negedge clk);
        chk("R4 push_ready low when full", push_ready, 0);
        step();
        drain_all();
        @(negedge clk);
        chk("R4 empty after four drains", drain_valid, 0);
        step();

        // R5: simultaneous push and drain
        try_push(16'h3000, 16'hC001, acc);
        try_push(16'h3010, 16'hC002, acc);
        drain_ready = 1'b1;
        try_push(16'h3020, 16'hC003, acc);
        drain_ready = 1'b0;
        chk("R5 push accepted during drain", acc, 1);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            try_push(16'h3100 + 16'(i * 16), 16'hC100 + 16'(i), acc);
            if (acc) cnt++;
        end
        chk("R5 room left after push+drain", cnt, 2);
        drain_all();

        // R9: read on empty queue
        rd_req = 1'b1; rd_addr = 16'h0500;
        @(negedge clk);
        chk("R9 grant on empty", rd_grant, 1);
        step();
        rd_req = 1'b0;

        // R6: no block match -> read first
        try_push(16'h0100, 16'hD001, acc);
        try_push(16'h0104, 16'hD002, acc);
        rd_req = 1'b1; rd_addr = 16'h0200;
        @(negedge clk);
        chk("R6 grant without match", rd_grant, 1);
        chk("R6 drain held off during grant", drain_valid, 0);
        step();
        rd_req = 1'b0;

        // R7: offset-only difference is a conflict
        rd_req = 1'b1; rd_addr = 16'h0106;
        @(negedge clk);
        chk("R7 no grant on block hit", rd_grant, 0);
        chk("R7 draining continues", drain_valid, 1);
        step();
        drain_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            g[i] = rd_grant;
        end
        chk("R7 grant held while match queued", g[1], 0);
        chk("R7 grant after match drained", g[2], 1);
        step();
        rd_req = 1'b0;
        drain_ready = 1'b0;
        chk("R7 scoreboard drained", exp_q.size(), 0);

        // R8: two matching entries among three
        try_push(16'h0300, 16'hE001, acc);
        try_push(16'h0400, 16'hE002, acc);
        try_push(16'h0302, 16'hE003, acc);
        rd_req = 1'b1; rd_addr = 16'h0303;
        step();
        drain_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            g[i] = rd_grant;
        end
        chk("R8 no grant after first match drained", g[1], 0);
        chk("R8 no grant before last match drained", g[2], 0);
        chk("R8 grant after last match drained", g[3], 1);
        step();
        rd_req = 1'b0;
        drain_ready = 1'b0;
        chk("R8 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule